// File: doc/BRIEF.md
# Read-Sequence Store Unlock Detector

This block watches the access stream of an SRAM-style port and decides when the host has unlocked a nonvolatile store. It does this without adding any pins. The host unlocks the store by issuing six read accesses, in a fixed order, to six fixed addresses. When the sixth read is accepted, the detector sends a single-cycle pulse to the store controller. Any other accepted access in the middle of the sequence breaks it.

Each access is presented as one clock cycle in which `strobe_i` is high. The cycle carries the 15-bit address, a chip-select level and a write level. An access counts only when chip-select is active. The output-enable level plays no part in the sequence, so the block has no input for it. While the store controller reports busy, the detector discards every access and holds itself idle. The current step count is exposed on `step_o` for debug.

Top module: `nv_unlock_det`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after release, `step_o` is 0 and `trig_o` is 0.
- R2: The unlock keys, in order, are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0. Accepted reads of all six, with no other accepted access between them, make `trig_o` high for exactly one cycle. That cycle is the one after the sixth read is sampled, and `step_o` returns to 0 in the same cycle.
- R3: `step_o` holds the number of keys matched so far (0 to 5). An accepted read of the next expected key raises it by exactly one.
- R4: An accepted read of an address other than the expected key (and other than the first key) sets `step_o` to 0. This includes an out-of-order key.
- R5: An accepted write (`we_i`=1) sets `step_o` to 0 without a pulse, even when its address is the expected key.
- R6: An accepted read of 0x0E38 that is not the expected key sets `step_o` to 1, so the sequence restarts at its second step.
- R7: A cycle with `strobe_i` low, or with `cs_i` low, leaves `step_o` unchanged and gives no pulse, whatever the address and write level.
- R8: While `busy_i` is high, accesses are ignored. The cycle after any busy cycle shows `step_o`=0 and `trig_o`=0. Once busy clears, a full sequence unlocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One accepted access slot this cycle |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | 15 | Access address |
| busy_i | input | 1 | Store controller busy; accesses ignored |
| trig_o | output | 1 | One-cycle store-start pulse |
| step_o | output | 3 | Keys matched so far (debug) |

## Verification
The checker module covers the behaviour that can be checked on every cycle:
- a pulse never lasts two cycles;
- a pulse only follows a count of 5;
- the count never exceeds 5 and never jumps upward by more than one;
- idle or deselected cycles leave the count frozen;
- a write or a busy cycle leaves the count at zero with no pulse.

Whether the keys, and their order, are the right ones can only be shown by the bench's directed scenarios. The same holds for the restart on the first key and for unlocking again after busy clears. Each of these scenarios drives a complete sequence and compares the count after every access.

// File: rtl/nv_unlock_pkg.sv
package nv_unlock_pkg;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned N_STEPS = 6;
  localparam int unsigned STEP_W  = $clog2(N_STEPS);

  function automatic logic [ADDR_W-1:0] key_at(input int unsigned idx);
    case (idx)
      0:       key_at = 15'h0E38;
      1:       key_at = 15'h31C7;
      2:       key_at = 15'h03E0;
      3:       key_at = 15'h3C1F;
      4:       key_at = 15'h303F;
      default: key_at = 15'h0FC0;
    endcase
  endfunction
endpackage

// File: rtl/nv_key_match.sv
module nv_key_match #(
  parameter int unsigned ADDR_W  = nv_unlock_pkg::ADDR_W,
  parameter int unsigned N_STEPS = nv_unlock_pkg::N_STEPS
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [N_STEPS-1:0] hit_o
);
  for (genvar k = 0; k < N_STEPS; k++) begin : g_key
    assign hit_o[k] = (addr_i == nv_unlock_pkg::key_at(k));
  end
endmodule

// File: rtl/nv_step_fsm.sv
module nv_step_fsm #(
  parameter int unsigned N_STEPS = nv_unlock_pkg::N_STEPS,
  parameter int unsigned STEP_W  = nv_unlock_pkg::STEP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic               we_i,
  input  logic               busy_i,
  input  logic [N_STEPS-1:0] hit_i,
  output logic               trig_o,
  output logic [STEP_W-1:0]  step_o
);
  localparam int unsigned HIT_W = 1 << STEP_W;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic              trig_q, fire;
  logic [HIT_W-1:0]  hit_pad;
  logic              rd;

  assign hit_pad = HIT_W'(hit_i);
  assign rd      = acc_i & ~we_i;

  always_comb begin
    step_d = step_q;
    fire   = 1'b0;
    if (busy_i) begin
      step_d = '0;
    end else if (acc_i) begin
      if (rd && hit_pad[step_q]) begin
        if (step_q == LAST) begin
          fire   = 1'b1;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else if (rd && hit_i[0]) begin
        step_d = STEP_W'(1); // mismatch on first key restarts past it
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      trig_q <= 1'b0;
    end else begin
      step_q <= step_d;
      trig_q <= fire;
    end
  end

  assign trig_o = trig_q;
  assign step_o = step_q;
endmodule

// File: rtl/nv_unlock_det.sv
module nv_unlock_det #(
  parameter int unsigned ADDR_W  = nv_unlock_pkg::ADDR_W,
  parameter int unsigned N_STEPS = nv_unlock_pkg::N_STEPS,
  parameter int unsigned STEP_W  = nv_unlock_pkg::STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              trig_o,
  output logic [STEP_W-1:0] step_o
);
  logic [N_STEPS-1:0] hit;
  logic               acc;

  assign acc = strobe_i & cs_i;

  nv_key_match #(.ADDR_W(ADDR_W), .N_STEPS(N_STEPS)) u_match (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  nv_step_fsm #(.N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .we_i   (we_i),
    .busy_i (busy_i),
    .hit_i  (hit),
    .trig_o (trig_o),
    .step_o (step_o)
  );
endmodule

// File: rtl/nv_unlock_det_chk.sv
module nv_unlock_det_chk #(
  parameter int unsigned N_STEPS = nv_unlock_pkg::N_STEPS,
  parameter int unsigned STEP_W  = nv_unlock_pkg::STEP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              cs_i,
  input logic              we_i,
  input logic              busy_i,
  input logic              trig_o,
  input logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r2_pulse_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(step_o) == LAST && step_o == '0));

  a_r3_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o <= LAST);

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o > STEP_W'(1)) |-> (step_o == $past(step_o) || step_o == $past(step_o) + 1'b1));

  a_r5_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && cs_i && we_i && !busy_i) |=> (step_o == '0 && !trig_o));

  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(strobe_i && cs_i) && !busy_i) |=> ($stable(step_o) && !trig_o));

  a_r8_busy_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (step_o == '0 && !trig_o));
endmodule

bind nv_unlock_det nv_unlock_det_chk #(.N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .cs_i     (cs_i),
  .we_i     (we_i),
  .busy_i   (busy_i),
  .trig_o   (trig_o),
  .step_o   (step_o)
);

// File: tb/nv_unlock_det_bench.sv
module nv_unlock_det_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe = 1'b0, cs = 1'b0, we = 1'b0, busy = 1'b0;
  logic [14:0] addr = '0;
  logic        trig;
  logic [2:0]  step;
  int          errors = 0, checks = 0;

  logic [14:0] keys [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0};

  always #2.5 clk = ~clk;

  nv_unlock_det u_nv_unlock_det (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .cs_i(cs), .we_i(we),
    .addr_i(addr), .busy_i(busy), .trig_o(trig), .step_o(step)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle access, outputs sampled at the following negedge
  task automatic access(input logic [14:0] a, input logic w, input logic c, input logic s);
    @(negedge clk);
    addr = a; we = w; cs = c; strobe = s;
    @(negedge clk);
    strobe = 1'b0; cs = 1'b0; we = 1'b0;
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) access(keys[i], 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 step", int'(step), 0);
    chk("R1 trig", int'(trig), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 step after release", int'(step), 0);
    chk("R1 trig after release", int'(trig), 0);
  endtask

  task automatic t_full_seq();
    for (int i = 0; i < 5; i++) begin
      access(keys[i], 1'b0, 1'b1, 1'b1);
      chk("R3 step advance", int'(step), i + 1);
      chk("R2 no early trig", int'(trig), 0);
    end
    access(keys[5], 1'b0, 1'b1, 1'b1);
    chk("R2 trig on sixth", int'(trig), 1);
    chk("R2 step cleared", int'(step), 0);
    @(negedge clk);
    chk("R2 pulse one cycle", int'(trig), 0);
  endtask

  task automatic t_wrong_addr();
    reads(3);
    access(15'h1234, 1'b0, 1'b1, 1'b1);
    chk("R4 abort on other addr", int'(step), 0);
    access(keys[2], 1'b0, 1'b1, 1'b1);
    chk("R4 out-of-order key", int'(step), 0);
  endtask

  task automatic t_write_abort();
    reads(2);
    access(keys[2], 1'b1, 1'b1, 1'b1);
    chk("R5 write to expected key", int'(step), 0);
    chk("R5 no trig", int'(trig), 0);
    reads(5);
    access(keys[5], 1'b1, 1'b1, 1'b1);
    chk("R5 write as sixth no trig", int'(trig), 0);
    chk("R5 write as sixth clears", int'(step), 0);
  endtask

  task automatic t_restart();
    reads(4);
    access(keys[0], 1'b0, 1'b1, 1'b1);
    chk("R6 restart at step one", int'(step), 1);
    for (int i = 1; i < 6; i++) access(keys[i], 1'b0, 1'b1, 1'b1);
    chk("R6 restarted sequence unlocks", int'(trig), 1);
  endtask

  task automatic t_ignored();
    reads(3);
    access(15'h7FFF, 1'b0, 1'b0, 1'b1);
    chk("R7 cs low ignored", int'(step), 3);
    access(15'h7FFF, 1'b1, 1'b1, 1'b0);
    chk("R7 strobe low ignored", int'(step), 3);
    access(keys[3], 1'b0, 1'b0, 1'b1);
    chk("R7 cs low key no advance", int'(step), 3);
    for (int i = 3; i < 6; i++) access(keys[i], 1'b0, 1'b1, 1'b1);
    chk("R7 sequence survives", int'(trig), 1);
  endtask

  task automatic t_busy();
    reads(3);
    @(negedge clk); busy = 1'b1;
    @(negedge clk);
    chk("R8 busy clears step", int'(step), 0);
    reads(6);
    chk("R8 busy no trig", int'(trig), 0);
    chk("R8 busy step idle", int'(step), 0);
    @(negedge clk); busy = 1'b0;
    reads(6);
    chk("R8 unlock after busy", int'(trig), 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_full_seq();
    t_wrong_addr();
    t_write_abort();
    t_restart();
    t_ignored();
    t_busy();
    t_full_seq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule